// File: doc/BRIEF.md
# Interpolation Window Address Fetcher

This block sits between a coordinate generator and a line-buffer SRAM. It serves a bilinear resampler. Each cycle it may receive one source coordinate, given as the integer column and row of the sample point. It keeps a small cached window of source rows, anchored at a reference column and row. A new fetch starts only when a coordinate leaves that window. The line buffer packs 16 pixels into each word and uses 120 words for each image row.

A fetch is a burst of row reads on consecutive cycles. The first read is the anchor row. The second read is the row below it, one line-length further on. An optional third read steps either one more row down or two rows back up. The step depends on the direction the sample moved across rows. For each returned word, one strobe per row marks which cache row it belongs to. For every coordinate, the block also outputs its column and row offset from the window anchor. These offsets are delayed so that they arrive with the last row of data. Outside fetch bursts the read strobe stays low, which leaves the SRAM port free for the writer.

Top module: `win_fetch`

## Requirements
- R1: After reset, `rd_en`, `row_vld` and `off_vld` are all low.
- R2: A fetching coordinate (u, v) drives `rd_en` high with `rd_addr` = v*120 + floor(u/16) on the cycle after it is presented. The multiply by 120 is done as (v<<7) - (v<<3).
- R3: In the next burst cycle `rd_addr` is the first address plus 120.
- R4: The third burst address is the second address plus 120 when (v[1:0] - previous anchor row[1:0]) mod 4 equals 1. In every other case it is the second address minus 240.
- R5: A coordinate inside the image starts a fetch when the column exceeds the anchor column by more than 6, or when the column is left of the anchor. It also starts a fetch when the row differs from the anchor row by more than one. A fetch moves the anchor to that coordinate. A coordinate inside the window starts no fetch.
- R6: A rising `line_sync` (high now, low on the previous cycle) drops the cached window. A coordinate arriving with it is fetched even if it lies inside the old window, and its offsets are zero.
- R7: A coordinate with a negative component, with column ≥ 1920, or with row ≥ 1080 starts no fetch and leaves the window unchanged. It is reported with `off_outside` = 1 and zero offsets.
- R8: `row_vld` is one-hot. Bit r rises exactly one cycle (the read latency) after the address for burst row r is issued.
- R9: Three cycles after the first address cycle of the coordinate's own slot, `off_vld` rises. At that point `off_u` = column minus anchor column (0 to 6, unsigned) and `off_v` = row minus anchor row (two-bit two's complement, -1 to +1).
- R10: `rd_en` is high only during the three cycles of a burst. It is low when there is no valid coordinate.
- R11: A fetch that occurs while a burst is running restarts the burst at row 0 with the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coord_vld | input | 1 | Coordinate valid |
| line_sync | input | 1 | Line sync; rising edge marks a new output line |
| coord_u | input | 13 | Signed integer source column |
| coord_v | input | 13 | Signed integer source row |
| rd_en | output | 1 | SRAM read strobe (high = read) |
| rd_addr | output | 17 | SRAM word address |
| row_vld | output | 3 | One-hot strobe per cache row for returned data |
| off_vld | output | 1 | Offset outputs valid |
| off_outside | output | 1 | Coordinate lay outside the image |
| off_u | output | 3 | Column offset from window anchor |
| off_v | output | 2 | Signed row offset from window anchor |

## Verification
The bench walks a single line of coordinates across every fetch trigger: a column jump of exactly 7, a backwards column move, a two-row jump and a line start inside the old window. A window check that is off by one would miss the column-7 refetch or would fire on an in-window point, and the expected offsets would be wrong. The third-row step is exercised in both directions, including a row difference that wraps modulo 4. A flipped comparison there would send the third read two rows off. A negative column checks that an off-image point neither moves the anchor nor issues a read; the next in-window coordinate shows that the anchor is unchanged. A restarted burst checks that a second fetch discards the unfinished row sequence instead of continuing it.

// File: rtl/waf_pkg.sv
package waf_pkg;
   // direction of the optional third row relative to the second one
   typedef enum logic {
      THIRD_UP   = 1'b0,   // one row above the anchor (step back two lines)
      THIRD_DOWN = 1'b1    // two rows below the anchor (step one more line)
   } third_dir_e;

   // modulo-4 row movement; a difference of exactly one means downward travel
   function automatic third_dir_e pick_dir(input logic [1:0] new_lo, input logic [1:0] old_lo);
      logic [1:0] diff;
      diff = new_lo - old_lo;
      return (diff == 2'b01) ? THIRD_DOWN : THIRD_UP;
   endfunction
endpackage

// File: rtl/waf_pipe.sv
module waf_pipe #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/waf_line_addr.sv
module waf_line_addr #(
   parameter int CW       = 13,
   parameter int AW       = 17,
   parameter int WPL      = 120,
   parameter int PPW_LOG2 = 4
) (
   input  logic signed [CW-1:0] u,
   input  logic signed [CW-1:0] v,
   output logic [AW-1:0]        addr
);
   logic [AW-1:0] v_w;
   logic [AW-1:0] row_base;
   logic [AW-1:0] col_word;

   assign v_w      = AW'($unsigned(v));
   assign col_word = AW'($unsigned(u) >> PPW_LOG2);

   generate
      if (WPL == 120) begin : g_shift_sub
         assign row_base = (v_w << 7) - (v_w << 3);
      end else begin : g_mult
         assign row_base = v_w * AW'(WPL);
      end
   endgenerate

   assign addr = row_base + col_word;
endmodule

// File: rtl/waf_window.sv
module waf_window
   import waf_pkg::*;
#(
   parameter int CW     = 13,
   parameter int IMG_W  = 1920,
   parameter int IMG_H  = 1080,
   parameter int U_SPAN = 6,
   parameter int UOW    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 coord_vld,
   input  logic                 line_sync,
   input  logic signed [CW-1:0] u,
   input  logic signed [CW-1:0] v,
   output logic                 fetch,
   output logic                 outside,
   output third_dir_e           dir,
   output logic [UOW-1:0]       u_off,
   output logic [1:0]           v_off
);
   logic signed [CW-1:0] u_src, v_src;
   logic                 win_vld, sync_d, line_start, far;
   logic signed [CW:0]   du, dv;

   assign line_start = line_sync && !sync_d;
   assign outside = (u < 0) || (v < 0) ||
                    (u >= CW'(IMG_W)) || (v >= CW'(IMG_H));

   assign du  = {u[CW-1], u} - {u_src[CW-1], u_src};
   assign dv  = {v[CW-1], v} - {v_src[CW-1], v_src};
   assign far = (du > (CW+1)'(U_SPAN)) || (du < 0) || (dv > 1) || (dv < -1);

   assign fetch = coord_vld && !outside && (!win_vld || line_start || far);
   assign dir   = pick_dir(v[1:0], v_src[1:0]);

   assign u_off = (fetch || outside) ? '0 : du[UOW-1:0];
   assign v_off = (fetch || outside) ? '0 : dv[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         u_src   <= '0;
         v_src   <= '0;
         win_vld <= 1'b0;
         sync_d  <= 1'b0;
      end else begin
         sync_d <= line_sync;
         if (fetch) begin
            u_src   <= u;
            v_src   <= v;
            win_vld <= 1'b1;
         end else if (line_start) begin
            win_vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/waf_burst.sv
module waf_burst
   import waf_pkg::*;
#(
   parameter int AW   = 17,
   parameter int WPL  = 120,
   parameter int ROWS = 3,
   parameter int RW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   base,
   input  third_dir_e      dir,
   output logic            rd_en,
   output logic [AW-1:0]   rd_addr,
   output logic [RW-1:0]   row,
   output logic [ROWS-1:0] row_oh
);
   localparam logic [AW-1:0] STEP_NEXT = AW'(WPL);
   localparam logic [AW-1:0] STEP_BACK = AW'(-2 * WPL);

   third_dir_e dir_q;
   logic [AW-1:0] step;

   assign step   = (row == '0 || dir_q == THIRD_DOWN) ? STEP_NEXT : STEP_BACK;
   assign row_oh = rd_en ? (ROWS'(1) << row) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_en   <= 1'b0;
         rd_addr <= '0;
         row     <= '0;
         dir_q   <= THIRD_UP;
      end else if (start) begin
         rd_en   <= 1'b1;
         rd_addr <= base;
         row     <= '0;
         dir_q   <= dir;
      end else if (rd_en) begin
         if (row == RW'(ROWS-1)) begin
            rd_en <= 1'b0;
            row   <= '0;
         end else begin
            row     <= row + 1'b1;
            rd_addr <= rd_addr + step;
         end
      end
   end
endmodule

// File: rtl/win_fetch.sv
module win_fetch
   import waf_pkg::*;
#(
   parameter int CW       = 13,
   parameter int AW       = 17,
   parameter int IMG_W    = 1920,
   parameter int IMG_H    = 1080,
   parameter int WPL      = 120,
   parameter int PPW_LOG2 = 4,
   parameter int ROWS     = 3,
   parameter int RD_LAT   = 1,
   parameter int U_SPAN   = 6,
   parameter int UOW      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 coord_vld,
   input  logic                 line_sync,
   input  logic signed [CW-1:0] coord_u,
   input  logic signed [CW-1:0] coord_v,
   output logic                 rd_en,
   output logic [AW-1:0]        rd_addr,
   output logic [ROWS-1:0]      row_vld,
   output logic                 off_vld,
   output logic                 off_outside,
   output logic [UOW-1:0]       off_u,
   output logic [1:0]           off_v
);
   localparam int RW     = (ROWS > 2) ? $clog2(ROWS) : 1;
   localparam int OFF_W  = 2 + UOW + 2;
   localparam int ALIGN  = ROWS + RD_LAT;

   generate
      if (ROWS < 2 || ROWS > 3) begin : g_bad_rows
         $error("win_fetch: ROWS must be 2 or 3");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("win_fetch: RD_LAT must be at least 1");
      end
      if (U_SPAN >= (1 << UOW)) begin : g_bad_span
         $error("win_fetch: U_SPAN does not fit in UOW bits");
      end
      if (longint'(WPL) * IMG_H > (longint'(1) << AW)) begin : g_bad_aw
         $error("win_fetch: AW too narrow for the frame");
      end
      if ((IMG_W >> PPW_LOG2) > WPL) begin : g_bad_wpl
         $error("win_fetch: WPL too small for IMG_W");
      end
   endgenerate

   logic                  fetch_need, coord_outside;
   third_dir_e            third_dir;
   logic [UOW-1:0]        u_off_c;
   logic [1:0]            v_off_c;
   logic [AW-1:0]         base_addr;
   logic [RW-1:0]         burst_row;
   logic [ROWS-1:0]       row_issue;
   logic [OFF_W-1:0]      off_in, off_out;

   waf_window #(
      .CW(CW), .IMG_W(IMG_W), .IMG_H(IMG_H), .U_SPAN(U_SPAN), .UOW(UOW)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .coord_vld(coord_vld), .line_sync(line_sync),
      .u(coord_u), .v(coord_v), .fetch(fetch_need), .outside(coord_outside),
      .dir(third_dir), .u_off(u_off_c), .v_off(v_off_c)
   );

   waf_line_addr #(
      .CW(CW), .AW(AW), .WPL(WPL), .PPW_LOG2(PPW_LOG2)
   ) u_addr (
      .u(coord_u), .v(coord_v), .addr(base_addr)
   );

   waf_burst #(
      .AW(AW), .WPL(WPL), .ROWS(ROWS), .RW(RW)
   ) u_burst (
      .clk(clk), .rst_n(rst_n), .start(fetch_need), .base(base_addr),
      .dir(third_dir), .rd_en(rd_en), .rd_addr(rd_addr), .row(burst_row),
      .row_oh(row_issue)
   );

   waf_pipe #(.W(ROWS), .DEPTH(RD_LAT)) u_row_pipe (
      .clk(clk), .rst_n(rst_n), .d(row_issue), .q(row_vld)
   );

   assign off_in = {coord_vld, coord_vld && coord_outside, u_off_c, v_off_c};

   waf_pipe #(.W(OFF_W), .DEPTH(ALIGN)) u_off_pipe (
      .clk(clk), .rst_n(rst_n), .d(off_in), .q(off_out)
   );

   assign {off_vld, off_outside, off_u, off_v} = off_out;
endmodule

// File: rtl/waf_chk.sv
module waf_chk #(
   parameter int AW     = 17,
   parameter int WPL    = 120,
   parameter int ROWS   = 3,
   parameter int RW     = 2,
   parameter int UOW    = 3,
   parameter int U_SPAN = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            coord_vld,
   input logic            fetch,
   input logic            outside,
   input logic            rd_en,
   input logic [AW-1:0]   rd_addr,
   input logic [RW-1:0]   burst_row,
   input logic [ROWS-1:0] row_vld,
   input logic            off_vld,
   input logic [UOW-1:0]  off_u
);
   // R2
   fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> (rd_en && burst_row == '0));

   // R3
   next_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !fetch && burst_row == '0) |=> (rd_addr == $past(rd_addr) + AW'(WPL)));

   // R10
   burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !fetch && burst_row == RW'(ROWS-1)) |=> !rd_en);

   // R10
   fetch_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |-> coord_vld);

   // R7
   outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coord_vld && outside) |-> !fetch);

   // R8
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_vld));

   // R9
   uoff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_vld |-> (off_u <= UOW'(U_SPAN)));
endmodule

bind win_fetch waf_chk #(
   .AW(AW), .WPL(WPL), .ROWS(ROWS), .RW(RW), .UOW(UOW), .U_SPAN(U_SPAN)
) u_waf_chk (
   .clk(clk), .rst_n(rst_n), .coord_vld(coord_vld), .fetch(fetch_need),
   .outside(coord_outside), .rd_en(rd_en), .rd_addr(rd_addr),
   .burst_row(burst_row), .row_vld(row_vld), .off_vld(off_vld), .off_u(off_u)
);

// File: tb/tb_win_fetch.sv
module tb_win_fetch;
   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                coord_vld = 1'b0;
   logic                line_sync = 1'b0;
   logic signed [12:0]  coord_u = '0;
   logic signed [12:0]  coord_v = '0;
   logic                rd_en;
   logic [16:0]         rd_addr;
   logic [2:0]          row_vld;
   logic                off_vld, off_outside;
   logic [2:0]          off_u;
   logic [1:0]          off_v;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   win_fetch dut (
      .clk(clk), .rst_n(rst_n), .coord_vld(coord_vld), .line_sync(line_sync),
      .coord_u(coord_u), .coord_v(coord_v), .rd_en(rd_en), .rd_addr(rd_addr),
      .row_vld(row_vld), .off_vld(off_vld), .off_outside(off_outside),
      .off_u(off_u), .off_v(off_v)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int base_of(input int u, input int v);
      return v * 120 + u / 16;
   endfunction

   // present one coordinate, then three idle cycles, checking every cycle
   task automatic run_coord(input int u, input int v, input bit sync,
                            input bit exp_fetch, input bit third_down,
                            input int exp_u, input int exp_v, input bit exp_out);
      int b;
      b = base_of(u, v);
      coord_vld = 1'b1; line_sync = sync;
      coord_u = 13'(u); coord_v = 13'(v);
      @(negedge clk);
      coord_vld = 1'b0;
      check("R10 rd_en first", rd_en, exp_fetch);
      if (exp_fetch) check("R2 base addr", rd_addr, b);
      @(negedge clk);
      check("R10 rd_en second", rd_en, exp_fetch);
      if (exp_fetch) check("R3 second row", rd_addr, b + 120);
      check("R8 strobe row0", row_vld, exp_fetch ? 3'b001 : 3'b000);
      @(negedge clk);
      check("R10 rd_en third", rd_en, exp_fetch);
      if (exp_fetch) check("R4 third row", rd_addr, third_down ? b + 240 : b - 120);
      check("R8 strobe row1", row_vld, exp_fetch ? 3'b010 : 3'b000);
      @(negedge clk);
      check("R10 rd_en idle", rd_en, 0);
      check("R8 strobe row2", row_vld, exp_fetch ? 3'b100 : 3'b000);
      check("R9 off_vld", off_vld, 1);
      check("R7 off_outside", off_outside, exp_out);
      check("R9 off_u", off_u, exp_u);
      check("R9 off_v", off_v, 2'(exp_v));
   endtask

   task automatic t_reset;
      check("R1 rd_en", rd_en, 0);
      check("R1 row_vld", row_vld, 0);
      check("R1 off_vld", off_vld, 0);
   endtask

   task automatic t_first_fetch;   // R6 line start, R4 step back
      run_coord(100, 10, 1, 1, 0, 0, 0, 0);
   endtask

   task automatic t_window;        // R5 triggers and in-window hits
      run_coord(104, 11, 1, 0, 0, 4, 1, 0);   // inside window
      run_coord(107, 10, 1, 1, 0, 0, 0, 0);   // column +7
      run_coord(108, 12, 1, 1, 0, 0, 0, 0);   // row +2
      run_coord(120, 13, 1, 1, 1, 0, 0, 0);   // R4 step down (diff 1)
      run_coord(110, 13, 1, 1, 0, 0, 0, 0);   // column moved left
   endtask

   task automatic t_outside;       // R7
      run_coord(-3, 13, 1, 0, 0, 0, 0, 1);
      run_coord(50, 1080, 1, 0, 0, 0, 0, 1);
      run_coord(111, 14, 1, 0, 0, 1, 1, 0);   // anchor still (110,13)
   endtask

   task automatic t_line_start;    // R6
      line_sync = 1'b0;
      @(negedge clk);
      run_coord(112, 13, 1, 1, 0, 0, 0, 0);
   endtask

   task automatic t_restart;       // R11
      coord_vld = 1'b1; coord_u = 13'(200); coord_v = 13'(13);
      @(negedge clk);
      check("R11 first base", rd_addr, 1572);
      coord_u = 13'(300); coord_v = 13'(20);
      @(negedge clk);
      coord_vld = 1'b0;
      check("R11 restart base", rd_addr, 2418);
      check("R11 rd_en", rd_en, 1);
      @(negedge clk);
      check("R11 second row", rd_addr, 2538);
      check("R8 restart strobe", row_vld, 3'b001);
      @(negedge clk);
      check("R4 wrap diff step back", rd_addr, 2298);
      @(negedge clk);
      check("R10 burst over", rd_en, 0);
   endtask

   task automatic t_idle;          // R10
      coord_vld = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R10 idle rd_en", rd_en, 0);
      end
      check("R10 idle off_vld", off_vld, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_fetch();
      t_window();
      t_outside();
      t_line_start();
      t_restart();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule